// File: doc/BRIEF.md
# Two-Class Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of peripheral sources (40 by default). Software assigns each source a 5-bit priority level, an enable and a class, either fast or normal. The controller then drives two request lines toward a processor, one for each class. A single vector number goes with them.

The vector comes in one of two forms. In autovector mode it is one of two fixed numbers. In vectored mode it is a range base plus the winning priority level. A control bit decides whether fast requests take their own vector range or share the normal one.

Two level-mask inputs, one for each class, let the processor side hide chosen priority levels. All outputs are registered. The request lines and the vector are plain level signals. They carry no handshake and cannot be back-pressured: they follow the sources continuously, one clock behind.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every source reads back as zero, which means disabled at level 0, and the control register reads zero. Both request outputs are low and `irq_vec` is 0.
- R2: The configuration register layout is as follows. Address 0 is the control register: bit 0 selects autovector mode and bit 1 selects a separate fast vector range, and its other bits read back as zero. Address 1+i configures source i: bits [4:0] hold the level, bit 5 is the enable and bit 6 selects the fast class. Reads return the stored value in the same cycle.
- R3: A pending, enabled source of the fast class can raise only `irq_fast`. A pending, enabled source of the normal class can raise only `irq_norm`.
- R4: In autovector mode the vector is 10 when only a normal request is presented and 11 when a fast request is presented.
- R5: In vectored mode a normal request presents vector 32 plus the winning level.
- R6: In vectored mode a fast request presents vector 64 plus its level when the separate-range bit is set, and 32 plus its level when that bit is clear.
- R7: Within a class the winner is the pending enabled source with the highest level; level 31 is the highest.
- R8: A source whose enable bit is clear never raises a request, whatever its input does.
- R9: When both classes have requests, `irq_vec` carries the fast vector and both request lines stay high.
- R10: Outputs are registered. A source change appears after exactly one rising clock edge, and a request falls one edge after its source input drops.
- R11: Setting bit L of `fast_mask` or `norm_mask` removes level L of that class from arbitration, so the next-highest unmasked level of that class wins.
- R12: When neither request line is high, `irq_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_irq | input | NUM_SRC | Level request from each source |
| fast_mask | input | 32 | Per-level suppression of fast requests |
| norm_mask | input | 32 | Per-level suppression of normal requests |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (0 control, 1+i source i) |
| cfg_wdata | input | 7 | Register write data |
| cfg_rdata | output | 7 | Register read data for `cfg_addr` |
| irq_fast | output | 1 | Fast-class request |
| irq_norm | output | 1 | Normal-class request |
| irq_vec | output | 8 | Vector number of the presented request |

## Verification
The hardest situation to reach is one where masking, class and mode all act at once. One example is a fast source that is masked out, so that a lower normal source has to win. Another is a fast source that beats a normal one, with the vector then switching between the shared range, the separate range and the autovector. The bench reaches these states by programming a fixed set of sources once. It picks them so that levels collide across classes and one source is configured but disabled. It then steps through a table of source patterns, masks and control values, each paired with the expected request lines and vector.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W  = 5;
  localparam int LEVELS = 1 << LVL_W;

  typedef struct packed {
    logic             fast;
    logic             en;
    logic [LVL_W-1:0] lvl;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);

  localparam int VEC_AUTO_NORM = 10;
  localparam int VEC_AUTO_FAST = 11;
  localparam int VEC_BASE_LO   = 32;
  localparam int VEC_BASE_HI   = 64;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output src_cfg_t          src_cfg [NUM_SRC],
  output logic              ctrl_ae,
  output logic              ctrl_fve
);
  localparam logic [CFG_W-1:0] CTRL_MASK = CFG_W'(3);

  logic [CFG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (cfg_we && cfg_addr == '0) begin
      ctrl_q <= cfg_wdata & CTRL_MASK;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_cfg[i] <= '0;
      end else if (cfg_we && cfg_addr == ADDR_W'(i + 1)) begin
        src_cfg[i] <= src_cfg_t'(cfg_wdata);
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == '0) cfg_rdata = ctrl_q;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfg_addr == ADDR_W'(i + 1)) cfg_rdata = src_cfg[i];
    end
  end

  assign ctrl_ae  = ctrl_q[0];
  assign ctrl_fve = ctrl_q[1];
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter bit IS_FAST = 1'b0
) (
  input  logic [NUM_SRC-1:0] src_irq,
  input  src_cfg_t           src_cfg [NUM_SRC],
  input  logic [LEVELS-1:0]  lvl_mask,
  output logic               found,
  output logic [LVL_W-1:0]   best_lvl
);
  logic [NUM_SRC-1:0] elig;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    assign elig[i] = src_irq[i] && src_cfg[i].en && (src_cfg[i].fast == IS_FAST)
                     && !lvl_mask[src_cfg[i].lvl];
  end

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!found || src_cfg[i].lvl > best_lvl)) begin
        found    = 1'b1;
        best_lvl = src_cfg[i].lvl;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int VEC_W   = 8,
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [LEVELS-1:0]  fast_mask,
  input  logic [LEVELS-1:0]  norm_mask,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               irq_fast,
  output logic               irq_norm,
  output logic [VEC_W-1:0]   irq_vec
);
  src_cfg_t         src_cfg [NUM_SRC];
  logic             ctrl_ae, ctrl_fve;
  logic             f_found, n_found;
  logic [LVL_W-1:0] f_lvl, n_lvl;
  logic [VEC_W-1:0] vec_d;

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_cfg(src_cfg),
    .ctrl_ae(ctrl_ae), .ctrl_fve(ctrl_fve)
  );

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .IS_FAST(1'b1)) u_arb_fast (
    .src_irq(src_irq), .src_cfg(src_cfg), .lvl_mask(fast_mask),
    .found(f_found), .best_lvl(f_lvl)
  );

  prio_irq_arb #(.NUM_SRC(NUM_SRC), .IS_FAST(1'b0)) u_arb_norm (
    .src_irq(src_irq), .src_cfg(src_cfg), .lvl_mask(norm_mask),
    .found(n_found), .best_lvl(n_lvl)
  );

  always_comb begin
    vec_d = '0;
    if (f_found) begin
      if (ctrl_ae)       vec_d = VEC_W'(VEC_AUTO_FAST);
      else if (ctrl_fve) vec_d = VEC_W'(VEC_BASE_HI) + VEC_W'(f_lvl);
      else               vec_d = VEC_W'(VEC_BASE_LO) + VEC_W'(f_lvl);
    end else if (n_found) begin
      if (ctrl_ae) vec_d = VEC_W'(VEC_AUTO_NORM);
      else         vec_d = VEC_W'(VEC_BASE_LO) + VEC_W'(n_lvl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_fast <= 1'b0;
      irq_norm <= 1'b0;
      irq_vec  <= '0;
    end else begin
      irq_fast <= f_found;
      irq_norm <= n_found;
      irq_vec  <= vec_d;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NUM_SRC = 40,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_irq,
  input logic               irq_fast,
  input logic               irq_norm,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               ae
);
  p_fast_has_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> $past(|src_irq));
  p_norm_has_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> $past(|src_irq));
  p_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_irq) |=> (!irq_fast && !irq_norm));
  p_auto_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fast && $past(ae)) |-> irq_vec == VEC_W'(11));
  p_auto_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_fast && irq_norm && $past(ae)) |-> irq_vec == VEC_W'(10));
  p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_fast || irq_norm) && !$past(ae)) |-> (irq_vec >= VEC_W'(32) && irq_vec < VEC_W'(96)));
  p_idle_vec_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_fast && !irq_norm) |-> irq_vec == '0);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .irq_fast(irq_fast),
  .irq_norm(irq_norm), .irq_vec(irq_vec), .ae(ctrl_ae)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int NS = 40;
  localparam int AW = 6;
  localparam int EW = 2 + NS + 32 + 32 + 1 + 1 + 8;
  localparam int NT = 16;

  // {ctrl, src, fast_mask, norm_mask, exp_fast, exp_norm, exp_vec}
  localparam logic [EW-1:0] TBL [NT] = '{
    {2'd0, 40'h0,            32'h0,         32'h0,  1'b0, 1'b0, 8'd0},  // R12
    {2'd0, 40'h1,            32'h0,         32'h0,  1'b0, 1'b1, 8'd35}, // R5 R3
    {2'd0, 40'h5,            32'h0,         32'h0,  1'b0, 1'b1, 8'd39}, // R7
    {2'd0, 40'h400,          32'h0,         32'h0,  1'b0, 1'b0, 8'd0},  // R8
    {2'd0, 40'h401,          32'h0,         32'h0,  1'b0, 1'b1, 8'd35}, // R8
    {2'd0, 40'h80,           32'h0,         32'h0,  1'b1, 1'b0, 8'd41}, // R6 shared, R3
    {2'd2, 40'h80,           32'h0,         32'h0,  1'b1, 1'b0, 8'd73}, // R6 own range
    {2'd2, 40'hA0,           32'h0,         32'h0,  1'b1, 1'b0, 8'd84}, // R7 fast
    {2'd2, 40'h24,           32'h0,         32'h0,  1'b1, 1'b1, 8'd84}, // R9
    {2'd1, 40'h24,           32'h0,         32'h0,  1'b1, 1'b1, 8'd11}, // R4 R9
    {2'd1, 40'h4,            32'h0,         32'h0,  1'b0, 1'b1, 8'd10}, // R4
    {2'd0, 40'h5,            32'h0,         32'h80, 1'b0, 1'b1, 8'd35}, // R11
    {2'd0, 40'h5,            32'h0,         32'h88, 1'b0, 1'b0, 8'd0},  // R11
    {2'd2, 40'hA0,           32'h0010_0000, 32'h0,  1'b1, 1'b0, 8'd73}, // R11 fast
    {2'd0, 40'h80_0000_0000, 32'h0,         32'h0,  1'b0, 1'b1, 8'd44}, // R5 top index
    {2'd2, 40'h24,           32'h0010_0000, 32'h0,  1'b0, 1'b1, 8'd39}  // R11 R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_irq = '0;
  logic [31:0]   fast_mask = '0, norm_mask = '0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [6:0]    cfg_wdata = '0;
  logic [6:0]    cfg_rdata;
  logic          irq_fast, irq_norm;
  logic [7:0]    irq_vec;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .fast_mask(fast_mask),
    .norm_mask(norm_mask), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_fast(irq_fast),
    .irq_norm(irq_norm), .irq_vec(irq_vec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [6:0] data);
    @(negedge clk);
    cfg_addr = AW'(addr); cfg_wdata = data; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input int addr, input logic [6:0] exp);
    @(negedge clk);
    cfg_addr = AW'(addr);
    #1 check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    src_irq = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 fast", 32'(irq_fast), 0);
    check("R1 norm", 32'(irq_norm), 0);
    check("R1 vec", 32'(irq_vec), 0);
    rd_check("R1 ctrl", 0, 7'h00);
    rd_check("R1 src0", 1, 7'h00);
    rd_check("R1 src39", 40, 7'h00);
    src_irq = '0;

    // configuration, R2 readback
    wr(1, 7'h23);  wr(3, 7'h27);  wr(6, 7'h74);
    wr(8, 7'h69);  wr(11, 7'h1F); wr(40, 7'h2C);
    wr(0, 7'h7F);
    rd_check("R2 ctrl upper bits", 0, 7'h03);
    rd_check("R2 src5", 6, 7'h74);
    rd_check("R2 src10", 11, 7'h1F);

    for (int i = 0; i < NT; i++) begin
      logic [EW-1:0] e;
      e = TBL[i];
      wr(0, {5'd0, e[EW-1 -: 2]});
      @(negedge clk);
      src_irq   = e[EW-3 -: NS];
      fast_mask = e[73:42];
      norm_mask = e[41:10];
      @(negedge clk);
      check($sformatf("R3 table %0d fast", i), 32'(irq_fast), 32'(e[9]));
      check($sformatf("R3 table %0d norm", i), 32'(irq_norm), 32'(e[8]));
      check($sformatf("R5 table %0d vec", i), 32'(irq_vec), 32'(e[7:0]));
    end

    // R10: one-edge latency, rise and fall
    wr(0, 7'h00);
    @(negedge clk);
    src_irq = '0; fast_mask = '0; norm_mask = '0;
    repeat (2) @(negedge clk);
    src_irq = 40'h1;
    #1 check("R10 not before edge", 32'(irq_norm), 0);
    @(posedge clk); #1;
    check("R10 after one edge", 32'(irq_norm), 1);
    check("R10 vec", 32'(irq_vec), 35);
    @(negedge clk);
    src_irq = '0;
    @(posedge clk); #1;
    check("R10 drop", 32'(irq_norm), 0);
    check("R12 idle vec", 32'(irq_vec), 0);

    // R8: disabling a pending source removes its request
    @(negedge clk);
    src_irq = 40'h1;
    wr(1, 7'h03);
    @(negedge clk);
    check("R8 disabled by write", 32'(irq_norm), 0);

    finish_run();
  end
endmodule